// File: doc/BRIEF.md
# Shared-Multiplier FIR / Complex-Multiply / Butterfly ALU

This block is a single-cycle fixed-point arithmetic unit built around four real multipliers and a small adder network. A two-bit mode input reconfigures operand multiplexers in front of the multipliers and adders. The same hardware can then act in one of three ways: one four-tap slice of a transposed-form FIR filter, a complex multiplier, or a radix-2 FFT butterfly. All values are signed two's-complement numbers of `W` bits, read as Q1.(W-1) fractions.

In FIR mode the four tap delay registers hold the slice state. An outside store saves and restores that state between calls. A load mode copies the state-in operands into the taps. A run mode takes one input sample and updates every tap. The taps can always be read on the state outputs. Several slices can be chained: the sample passes out on the top output, and each slice's filtered partial sum comes out on its bottom output. The complex modes use the same multipliers and never touch the taps. Registers change only on a clock edge where the fire strobe is high.

Top module: `fbc_alu`

## Requirements
- R1: A synchronous active-high reset clears all four tap registers to zero. The state outputs therefore read zero after the reset edge.
- R2: Mode 2'b01 (state load): on a fire edge, tap register i takes state-in lane i. While this mode is selected, all four result lanes are zero.
- R3: Mode 2'b00 (FIR run): lane i computes tap sum s_i = c_i·x + t_(i+1) for i = 0..2, where x is data lane 0 and t is the current tap register. Result lane 0 carries x unchanged (top output) and result lane 1 carries s_0 (bottom output), combinationally. Lanes 2 and 3 are zero. On a fire edge, each tap i takes s_i.
- R4: In FIR run, tap 3's sum is s_3 = c_3·x + b, where b is data lane 1 (the bottom input). With b held at zero and the taps starting at zero, result lane 1 is the four-tap convolution of the samples with c_0..c_3.
- R5: Every product is the full 2W-bit signed product, shifted right arithmetically by W-1, with the low W bits kept. Every sum and difference wraps modulo 2^W. There is no saturation, so (-1)·(-1) yields -1.
- R6: Mode 2'b10 (complex multiply): Z1 = data lanes 0 (re) and 1 (im). Z2 = coefficient lanes 0 (re) and 1 (im), repeated in lanes 2 (re) and 3 (im). Result lane 0 is re(Z1·Z2), lane 1 is im(Z1·Z2), and lanes 2 and 3 are zero.
- R7: Mode 2'b11 (butterfly): x0 = data lanes 0/1 and x1 = data lanes 2/3 (re/im). The twiddle W sits in coefficient lanes as in R6. Result lanes 0/1 are x0 + W·x1 and lanes 2/3 are x0 − W·x1.
- R8: In the complex-multiply and butterfly modes the tap registers keep their values, even on a fire edge.
- R9: Without fire, no mode changes the tap registers.
- R10: State output lane i always shows tap register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the tap registers |
| fire | input | 1 | Update strobe for the tap registers |
| mode | input | 2 | 00 FIR run, 01 state load, 10 complex multiply, 11 butterfly |
| din_i | input | 4*W | Data operands, lane i in bits [i*W +: W] |
| coef_i | input | 4*W | Coefficients / multiplier constants, one per lane |
| state_i | input | 4*W | Values loaded into the taps in state-load mode |
| res_o | output | 4*W | Result lanes (combinational) |
| state_o | output | 4*W | Current tap register contents |

## Verification
The assertions take the complex modes to be driven in the duplicated-constant form: coefficient lane 2 equals lane 0 and lane 3 equals lane 1. The butterfly pair check relies only on that layout and on wrap-around arithmetic. The stimulus builds every complex-mode coefficient set by copying the real and imaginary parts, so it never leaves that form. The reset and hold properties assume that fire is meaningful only outside reset. The bench mixes fire-high and fire-low cycles in all four modes, including full-scale negative operands.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        MODE_FIR_RUN  = 2'b00,
        MODE_FIR_LOAD = 2'b01,
        MODE_CMUL     = 2'b10,
        MODE_BFLY     = 2'b11
    } alu_mode_e;

    typedef struct packed {
        logic tap_run;   // taps take the tap sums
        logic tap_load;  // taps take state-in
        logic cplx;      // multipliers fed in complex pairing
        logic bfly;      // butterfly post-adders active
    } ctrl_t;

    function automatic ctrl_t decode_mode(alu_mode_e m);
        ctrl_t c;
        c = '0;
        unique case (m)
            MODE_FIR_RUN:  c.tap_run  = 1'b1;
            MODE_FIR_LOAD: c.tap_load = 1'b1;
            MODE_CMUL:     c.cplx     = 1'b1;
            MODE_BFLY: begin
                c.cplx = 1'b1;
                c.bfly = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fbc_mul_bank.sv
module fbc_mul_bank
    import fbc_pkg::*;
#(
    parameter int W = 16
) (
    input  ctrl_t                      ctrl,
    input  logic [LANES-1:0][W-1:0]    din_i,
    input  logic [LANES-1:0][W-1:0]    coef_i,
    output logic [LANES-1:0][W-1:0]    prod_o
);
    localparam int PW    = 2 * W;
    localparam int SHIFT = W - 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // complex pairing: lanes 2/3 swap coefficients to form cross terms
        localparam int CSEL = (i < 2) ? i : (LANES + 1 - i);
        localparam int PAIR = i % 2;

        logic signed [W-1:0]  op_a;
        logic signed [W-1:0]  op_b;
        logic signed [PW-1:0] full;

        always_comb begin
            if (!ctrl.cplx) begin
                op_a = din_i[0];
                op_b = coef_i[i];
            end else if (ctrl.bfly) begin
                op_a = din_i[2 + PAIR];
                op_b = coef_i[CSEL];
            end else begin
                op_a = din_i[PAIR];
                op_b = coef_i[CSEL];
            end
        end

        assign full      = op_a * op_b;
        assign prod_o[i] = W'(full >>> SHIFT);
    end

endmodule

// File: rtl/fbc_add_stage.sv
module fbc_add_stage
    import fbc_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_mode_e                  mode,
    input  ctrl_t                      ctrl,
    input  logic [LANES-1:0][W-1:0]    din_i,
    input  logic [LANES-1:0][W-1:0]    prod_i,
    input  logic [LANES-1:0][W-1:0]    taps_i,
    output logic [LANES-1:0][W-1:0]    sum_o,
    output logic [LANES-1:0][W-1:0]    res_o
);
    // chained operand of each tap: next tap's register, bottom input for the last
    logic [LANES-1:0][W-1:0] chain;

    for (genvar i = 0; i < LANES; i++) begin : g_chain
        if (i < LANES - 1) begin : g_mid
            assign chain[i] = taps_i[i+1];
        end else begin : g_end
            assign chain[i] = din_i[1];
        end
    end

    // lane 0: switchable add/sub (tap sum or real part of the product)
    logic [W-1:0] l0_b;
    assign l0_b     = ctrl.cplx ? prod_i[1] : chain[0];
    assign sum_o[0] = ctrl.cplx ? (prod_i[0] - l0_b) : (prod_i[0] + l0_b);

    // lane 1: fixed adder, operands muxed (tap sum or imaginary part)
    logic [W-1:0] l1_a, l1_b;
    assign l1_a     = ctrl.cplx ? prod_i[2] : prod_i[1];
    assign l1_b     = ctrl.cplx ? prod_i[3] : chain[1];
    assign sum_o[1] = l1_a + l1_b;

    // lanes 2..3: fixed tap adders
    for (genvar i = 2; i < LANES; i++) begin : g_tail
        assign sum_o[i] = prod_i[i] + chain[i];
    end

    // butterfly post-adders
    logic [W-1:0] bf_p_re, bf_p_im, bf_m_re, bf_m_im;
    assign bf_p_re = din_i[0] + sum_o[0];
    assign bf_p_im = din_i[1] + sum_o[1];
    assign bf_m_re = din_i[0] - sum_o[0];
    assign bf_m_im = din_i[1] - sum_o[1];

    always_comb begin
        res_o = '0;
        unique case (mode)
            MODE_FIR_RUN: begin
                res_o[0] = din_i[0];
                res_o[1] = sum_o[0];
            end
            MODE_FIR_LOAD: res_o = '0;
            MODE_CMUL: begin
                res_o[0] = sum_o[0];
                res_o[1] = sum_o[1];
            end
            MODE_BFLY: begin
                res_o[0] = bf_p_re;
                res_o[1] = bf_p_im;
                res_o[2] = bf_m_re;
                res_o[3] = bf_m_im;
            end
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/fbc_tap_regs.sv
module fbc_tap_regs
    import fbc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fire,
    input  ctrl_t                      ctrl,
    input  logic [LANES-1:0][W-1:0]    sum_i,
    input  logic [LANES-1:0][W-1:0]    state_i,
    output logic [LANES-1:0][W-1:0]    taps_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                taps_o[i] <= '0;
            end else if (fire && ctrl.tap_load) begin
                taps_o[i] <= state_i[i];
            end else if (fire && ctrl.tap_run) begin
                taps_o[i] <= sum_i[i];
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (taps_o == '0)); // R1

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        (fire && ctrl.tap_load) |=> (taps_o == $past(state_i))); // R2

    AST_CPLX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fire && ctrl.cplx) |=> $stable(taps_o)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(taps_o)); // R9

endmodule

// File: rtl/fbc_alu.sv
module fbc_alu
    import fbc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fire,
    input  logic [1:0]                 mode,
    input  logic [LANES-1:0][W-1:0]    din_i,
    input  logic [LANES-1:0][W-1:0]    coef_i,
    input  logic [LANES-1:0][W-1:0]    state_i,
    output logic [LANES-1:0][W-1:0]    res_o,
    output logic [LANES-1:0][W-1:0]    state_o
);
    alu_mode_e               mode_e;
    ctrl_t                   ctrl;
    logic [LANES-1:0][W-1:0] prod;
    logic [LANES-1:0][W-1:0] tap_sum;
    logic [LANES-1:0][W-1:0] taps;

    assign mode_e  = alu_mode_e'(mode);
    assign ctrl    = decode_mode(mode_e);
    assign state_o = taps;

    fbc_mul_bank #(.W(W)) u_mul (
        .ctrl   (ctrl),
        .din_i  (din_i),
        .coef_i (coef_i),
        .prod_o (prod)
    );

    fbc_add_stage #(.W(W)) u_add (
        .mode   (mode_e),
        .ctrl   (ctrl),
        .din_i  (din_i),
        .prod_i (prod),
        .taps_i (taps),
        .sum_o  (tap_sum),
        .res_o  (res_o)
    );

    fbc_tap_regs #(.W(W)) u_taps (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .ctrl    (ctrl),
        .sum_i   (tap_sum),
        .state_i (state_i),
        .taps_o  (taps)
    );

    AST_FIR_BOTTOM_STORED: assert property (@(posedge clk) disable iff (rst)
        (fire && mode == MODE_FIR_RUN) |=> (state_o[0] == $past(res_o[1]))); // R3

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FIR_LOAD) |-> (res_o == '0)); // R2

    AST_CMUL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CMUL) |-> (res_o[2] == '0 && res_o[3] == '0)); // R6

    AST_BFLY_PAIR_SUM: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BFLY) |-> (W'(res_o[0] + res_o[2]) == W'({din_i[0], 1'b0}))); // R7

endmodule

// File: tb/fbc_alu_tb_top.sv
module fbc_alu_tb_top;
    localparam int W     = 16;
    localparam int CLK_P = 10;
    localparam int NL    = 4;
    localparam int MAXV  = (1 << (W - 1)) - 1;
    localparam int MINV  = -(1 << (W - 1));

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  fire = 1'b0;
    logic [1:0]            mode = 2'b00;
    logic [NL-1:0][W-1:0]  din = '0, coef = '0, sin = '0;
    logic [NL-1:0][W-1:0]  res, sout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int taps_m [NL];

    always #(CLK_P / 2) clk = ~clk;

    fbc_alu #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .fire(fire), .mode(mode),
        .din_i(din), .coef_i(coef), .state_i(sin),
        .res_o(res), .state_o(sout)
    );

    function automatic int wr(longint v);
        logic signed [W-1:0] t;
        t = v[W-1:0];
        return int'(t);
    endfunction

    function automatic int scl(int a, int b);
        longint p;
        p = longint'(a) * longint'(b);
        p = p >>> (W - 1);
        return wr(p);
    endfunction

    function automatic int rnd();
        return wr(longint'($urandom));
    endfunction

    task automatic chk(int act, int exp_v, string tag);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    // one cycle: drive, compare combinational results and state, then clock
    task automatic step(int md, int d[NL], int k[NL], int s[NL], bit f, string tag);
        int ey[NL];
        int nx[NL];
        int tre, tim;
        @(negedge clk);
        mode = 2'(md);
        fire = f;
        for (int i = 0; i < NL; i++) begin
            din[i]  = W'(d[i]);
            coef[i] = W'(k[i]);
            sin[i]  = W'(s[i]);
            ey[i]   = 0;
            nx[i]   = taps_m[i];
        end
        case (md)
            0: begin
                for (int i = 0; i < NL; i++)
                    nx[i] = wr(longint'(scl(d[0], k[i])) + ((i < NL - 1) ? taps_m[i+1] : d[1]));
                ey[0] = d[0];
                ey[1] = nx[0];
            end
            1: for (int i = 0; i < NL; i++) nx[i] = s[i];
            2: begin
                ey[0] = wr(longint'(scl(d[0], k[0])) - scl(d[1], k[1]));
                ey[1] = wr(longint'(scl(d[0], k[3])) + scl(d[1], k[2]));
            end
            default: begin
                tre   = wr(longint'(scl(d[2], k[0])) - scl(d[3], k[1]));
                tim   = wr(longint'(scl(d[2], k[3])) + scl(d[3], k[2]));
                ey[0] = wr(longint'(d[0]) + tre);
                ey[1] = wr(longint'(d[1]) + tim);
                ey[2] = wr(longint'(d[0]) - tre);
                ey[3] = wr(longint'(d[1]) - tim);
            end
        endcase
        #1;
        for (int i = 0; i < NL; i++) begin
            chk(int'($signed(res[i])), ey[i], $sformatf("%s res lane %0d", tag, i));
            chk(int'($signed(sout[i])), taps_m[i], $sformatf("R10 state lane %0d", i));
        end
        @(posedge clk);
        if (f && (md == 0 || md == 1))
            for (int i = 0; i < NL; i++) taps_m[i] = nx[i];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        fire = 1'b1;
        mode = 2'b01;
        for (int i = 0; i < NL; i++) sin[i] = W'(i + 7);
        @(posedge clk);
        @(negedge clk);
        rst  = 1'b0;
        fire = 1'b0;
        for (int i = 0; i < NL; i++) taps_m[i] = 0;
        #1;
        for (int i = 0; i < NL; i++)
            chk(int'($signed(sout[i])), 0, $sformatf("R1 reset lane %0d", i));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int z[NL];
        int d[NL], k[NL], s[NL];
        int re, im;
        z = '{0, 0, 0, 0};
        for (int i = 0; i < NL; i++) taps_m[i] = 0;
        repeat (2) @(posedge clk);
        do_reset();

        // R2: load state, then R9: no fire leaves it alone
        s = '{100, -200, 300, -400};
        step(1, z, z, s, 1'b1, "R2 load");
        step(1, '{5, 6, 7, 8}, '{1, 2, 3, 4}, '{9, 9, 9, 9}, 1'b0, "R9 idle load");
        step(0, '{1234, 55, 0, 0}, '{8000, 8000, 8000, 8000}, z, 1'b0, "R9 idle run");

        // R8: complex modes with fire do not touch taps
        step(2, '{16384, -8192, 0, 0}, '{16384, 8192, 16384, 8192}, z, 1'b1, "R6 cmul");
        step(3, '{1000, -1000, 16384, 16384}, '{23170, -23170, 23170, -23170}, z, 1'b1, "R7 bfly");
        step(0, '{0, 0, 0, 0}, z, z, 1'b0, "R8 taps kept");

        // R4: impulse response of one slice, bottom input zero
        step(1, z, z, z, 1'b1, "R2 clear");
        k = '{1000, -2000, 3000, 4000};
        step(0, '{16384, 0, 0, 0}, k, z, 1'b1, "R4 impulse");
        for (int n = 0; n < 5; n++) step(0, z, k, z, 1'b1, "R4 impulse tail");
        // R4: nonzero bottom input enters tap 3
        step(0, '{0, 1500, 0, 0}, k, z, 1'b1, "R4 bottom in");
        for (int n = 0; n < 4; n++) step(0, z, k, z, 1'b1, "R4 bottom tail");

        // R5: full-scale corners wrap
        step(2, '{MINV, 0, 0, 0}, '{MINV, 0, MINV, 0}, z, 1'b0, "R5 min*min");
        step(2, '{MAXV, MINV, 0, 0}, '{MAXV, MAXV, MAXV, MAXV}, z, 1'b0, "R5 wrap");
        step(3, '{MAXV, MAXV, MINV, MINV}, '{MINV, MINV, MINV, MINV}, z, 1'b0, "R5 bfly wrap");
        step(0, '{MINV, MAXV, 0, 0}, '{MINV, MAXV, MINV, MAXV}, z, 1'b1, "R5 fir wrap");

        // mixed random stream
        for (int n = 0; n < 600; n++) begin
            int md;
            bit f;
            md = int'($urandom_range(0, 3));
            f  = ($urandom_range(0, 3) != 0);
            for (int i = 0; i < NL; i++) begin
                d[i] = rnd();
                s[i] = rnd();
                k[i] = rnd();
            end
            if (md >= 2) begin
                re = k[0];
                im = k[1];
                k  = '{re, im, re, im};
            end
            case (md)
                0: step(md, d, k, s, f, "R3 run");
                1: step(md, d, k, s, f, "R2 load");
                2: step(md, d, k, s, f, "R6 cmul");
                default: step(md, d, k, s, f, "R7 bfly");
            endcase
        end

        do_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule